// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block walks a DDR2 memory controller through the power-up and mode-programming sequence before any normal traffic is allowed. It leaves reset on its own and then presents one command at a time on a valid/ready command port. Each command carries a type, an address and a data word. After each accepted command it waits for a fixed number of clock cycles. It also drives three side controls into the controller: the clock-enable pin level, the DLL-reset configuration bit and the OCD-default calibration bit.

The sequence has twenty fixed steps. Fifteen of them issue commands and five only change a control bit. The extended mode registers are selected by writing their index onto the bank-address bits, which sit at address bit `BA_LSB`. Every wait is given in nanoseconds and converted to clock cycles from the `CLK_MHZ` parameter, rounding up. When the final write has been accepted, the block raises `init_done_o` and presents the refresh-interval value to the controller. The block then stays idle until it is reset again.

Top module: `ddr2_init_seq`

## Requirements
- R1: While `rst_ni` is low, `cmd_valid_o`, `cke_o`, `dll_rst_o`, `ocd_dflt_o` and `init_done_o` are 0 and `refresh_int_o` is 0.
- R2: While `cmd_valid_o` is high and `cmd_ready_i` is low, the command is held with `cmd_type_o`, `cmd_addr_o` and `cmd_data_o` unchanged. A command is accepted in the cycle that has both valid and ready high, and it is accepted exactly once.
- R3: The command types appear in this order, using the encoding NOP=0, precharge-all=1, mode load=2, extended mode load=3, auto-refresh=4, normal-mode=5, write=6:
  - NOP, NOP, precharge-all;
  - extended mode loads for index 2, then 3, then 1;
  - mode load, precharge-all, auto-refresh, auto-refresh;
  - mode load, extended load 1, extended load 1;
  - normal-mode, write.
- R4: An extended mode load carries its index (2, 3 or 1) in `cmd_addr_o[BA_LSB+1:BA_LSB]`, with `BA_LSB`=12 by default, and zeros elsewhere. Every other command carries address 0.
- R5: The number of cycles with `cmd_valid_o` low, counted from the cycle after one acceptance to the next command, is set as follows (cyc(t) = ceil(t × CLK_MHZ / 1000)):
  - cyc(200000 ns) after the first NOP;
  - cyc(200 ns) after the second NOP;
  - cyc(1000 ns) after the EMR3 and first EMR1 loads;
  - cyc(400 ns) after the second precharge and after each auto-refresh;
  - cyc(15 ns) after the other commands.
  - Each bit-only step adds one cycle plus its own wait: 0 for the two DLL-reset changes, cyc(15 ns) for the OCD enter and exit.
- R6: `cke_o` is 0 until the second NOP is accepted and is 1 from the next cycle on. No command other than NOP is issued while `cke_o` is 0.
- R7: `dll_rst_o` is 1 during the first mode load, the precharge after it and both auto-refreshes. It is 0 during the second mode load and every other command.
- R8: `ocd_dflt_o` is 1 during the first of the two EMR1 loads that follow the second mode load and 0 during all other commands. It is never 1 together with `dll_rst_o`.
- R9: Both mode loads carry data `(CAS_LAT<<4)|2`, which is 0x32 by default. The write carries `WR_PATTERN`, which is 0xA5A5A5D1 by default. All other commands carry data 0.
- R10: `init_done_o` and `refresh_int_o` stay 0 until one cycle after the write is accepted. From then on `init_done_o`=1, `refresh_int_o`=`REF_INT` (0x40F) and no further command is issued.
- R11: A reset in the middle of the sequence clears all controls. After reset the sequence starts again from the first NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_o | output | 1 | Command present on the command port |
| cmd_ready_i | input | 1 | Controller accepts the command this cycle |
| cmd_type_o | output | 3 | Command type code |
| cmd_addr_o | output | ADDR_W | Command address; bank bits select the extended mode register |
| cmd_data_o | output | DATA_W | Mode value or write data |
| cke_o | output | 1 | Clock-enable level |
| dll_rst_o | output | 1 | DLL-reset configuration bit |
| ocd_dflt_o | output | 1 | OCD default calibration bit |
| init_done_o | output | 1 | Initialization complete |
| refresh_int_o | output | REF_W | Refresh-interval value, valid once done |

## Verification
Two events can fall in the same clock edge: the acceptance of a command, and the loading of the wait counter that governs the next step. When the controller keeps ready high, a command is taken on its first valid cycle. The end of one wait then runs directly into the next handshake. When ready is stalled at random, the wait must not start until the acceptance. The bench runs the sequence once with ready held high and once with random stalls. In both runs it judges each gap by the exact count of idle cycles its own timing function predicts, so a wait that starts too early or too late is reported. A reset placed midway while the DLL-reset bit is set shows that the restart leaves no stale control behind.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PREA = 3'd1,
    CMD_MRS  = 3'd2,
    CMD_EMRS = 3'd3,
    CMD_REF  = 3'd4,
    CMD_NORM = 3'd5,
    CMD_WR   = 3'd6,
    CMD_NONE = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    ACT_NONE, ACT_CKE_ON, ACT_DLL_SET, ACT_DLL_CLR, ACT_OCD_SET, ACT_OCD_CLR, ACT_DONE
  } act_e;

  typedef enum logic [2:0] {
    W_ZERO, W_CMD, W_CKE, W_PWR, W_SETTLE, W_RFC
  } wait_e;

  typedef struct packed {
    cmd_e       cmd;
    logic [1:0] emr_idx;
    act_e       act;
    wait_e      wt;
  } step_t;

  localparam int unsigned NUM_STEPS = 20;
  localparam int unsigned STEP_W    = $clog2(NUM_STEPS);

  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned mhz);
    longint unsigned p;
    p = longint'(ns) * longint'(mhz) + 64'd999;
    return int'(p / 64'd1000);
  endfunction

  function automatic int unsigned maxu(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // fixed power-up ordering
  function automatic step_t step_of(logic [STEP_W-1:0] i);
    case (i)
      5'd0:    return '{CMD_NOP,  2'd0, ACT_NONE,    W_PWR};
      5'd1:    return '{CMD_NOP,  2'd0, ACT_CKE_ON,  W_CKE};
      5'd2:    return '{CMD_PREA, 2'd0, ACT_NONE,    W_CMD};
      5'd3:    return '{CMD_EMRS, 2'd2, ACT_NONE,    W_CMD};
      5'd4:    return '{CMD_EMRS, 2'd3, ACT_NONE,    W_SETTLE};
      5'd5:    return '{CMD_EMRS, 2'd1, ACT_NONE,    W_SETTLE};
      5'd6:    return '{CMD_NONE, 2'd0, ACT_DLL_SET, W_ZERO};
      5'd7:    return '{CMD_MRS,  2'd0, ACT_NONE,    W_CMD};
      5'd8:    return '{CMD_PREA, 2'd0, ACT_NONE,    W_RFC};
      5'd9:    return '{CMD_REF,  2'd0, ACT_NONE,    W_RFC};
      5'd10:   return '{CMD_REF,  2'd0, ACT_NONE,    W_RFC};
      5'd11:   return '{CMD_NONE, 2'd0, ACT_DLL_CLR, W_ZERO};
      5'd12:   return '{CMD_MRS,  2'd0, ACT_NONE,    W_CMD};
      5'd13:   return '{CMD_NONE, 2'd0, ACT_OCD_SET, W_CMD};
      5'd14:   return '{CMD_EMRS, 2'd1, ACT_NONE,    W_CMD};
      5'd15:   return '{CMD_NONE, 2'd0, ACT_OCD_CLR, W_CMD};
      5'd16:   return '{CMD_EMRS, 2'd1, ACT_NONE,    W_CMD};
      5'd17:   return '{CMD_NORM, 2'd0, ACT_NONE,    W_CMD};
      5'd18:   return '{CMD_WR,   2'd0, ACT_NONE,    W_ZERO};
      default: return '{CMD_NONE, 2'd0, ACT_DONE,    W_ZERO};
    endcase
  endfunction

endpackage

// File: rtl/ddr2_init_steps.sv
module ddr2_init_steps
  import ddr2_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 200,
  parameter int unsigned T_PWR_NS  = 200000,
  parameter int unsigned T_CKE_NS  = 200,
  parameter int unsigned T_CMD_NS  = 15,
  parameter int unsigned T_SETL_NS = 1000,
  parameter int unsigned T_RFC_NS  = 400,
  parameter int unsigned CNT_W     = 16
) (
  input  logic [STEP_W-1:0] step_i,
  output cmd_e              cmd_o,
  output logic [1:0]        emr_idx_o,
  output act_e              act_o,
  output logic [CNT_W-1:0]  wait_cyc_o
);
  localparam logic [CNT_W-1:0] C_CMD = CNT_W'(ns2cyc(T_CMD_NS,  CLK_MHZ));
  localparam logic [CNT_W-1:0] C_CKE = CNT_W'(ns2cyc(T_CKE_NS,  CLK_MHZ));
  localparam logic [CNT_W-1:0] C_PWR = CNT_W'(ns2cyc(T_PWR_NS,  CLK_MHZ));
  localparam logic [CNT_W-1:0] C_SET = CNT_W'(ns2cyc(T_SETL_NS, CLK_MHZ));
  localparam logic [CNT_W-1:0] C_RFC = CNT_W'(ns2cyc(T_RFC_NS,  CLK_MHZ));

  step_t cur;
  assign cur       = step_of(step_i);
  assign cmd_o     = cur.cmd;
  assign emr_idx_o = cur.emr_idx;
  assign act_o     = cur.act;

  always_comb begin
    unique case (cur.wt)
      W_CMD:    wait_cyc_o = C_CMD;
      W_CKE:    wait_cyc_o = C_CKE;
      W_PWR:    wait_cyc_o = C_PWR;
      W_SETTLE: wait_cyc_o = C_SET;
      W_RFC:    wait_cyc_o = C_RFC;
      default:  wait_cyc_o = '0;
    endcase
  end
endmodule

// File: rtl/ddr2_wait_cnt.sv
module ddr2_wait_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(1));

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> cnt_q == '0); // R5
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int unsigned    CLK_MHZ    = 200,
  parameter int unsigned    T_PWR_NS   = 200000,
  parameter int unsigned    T_CKE_NS   = 200,
  parameter int unsigned    T_CMD_NS   = 15,
  parameter int unsigned    T_SETL_NS  = 1000,
  parameter int unsigned    T_RFC_NS   = 400,
  parameter int unsigned    ADDR_W     = 32,
  parameter int unsigned    DATA_W     = 32,
  parameter int unsigned    BA_LSB     = 12,
  parameter int unsigned    CAS_LAT    = 3,
  parameter int unsigned    REF_W      = 12,
  parameter logic [REF_W-1:0]  REF_INT    = 12'h40F,
  parameter logic [DATA_W-1:0] WR_PATTERN = 32'hA5A5A5D1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [2:0]        cmd_type_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic              cke_o,
  output logic              dll_rst_o,
  output logic              ocd_dflt_o,
  output logic              init_done_o,
  output logic [REF_W-1:0]  refresh_int_o
);
  localparam int unsigned MAX_CYC = maxu(maxu(ns2cyc(T_PWR_NS, CLK_MHZ), ns2cyc(T_CKE_NS, CLK_MHZ)),
                                         maxu(maxu(ns2cyc(T_CMD_NS, CLK_MHZ), ns2cyc(T_SETL_NS, CLK_MHZ)),
                                              ns2cyc(T_RFC_NS, CLK_MHZ)));
  localparam int unsigned CNT_W = $clog2(MAX_CYC + 1);
  localparam logic [DATA_W-1:0] MR_VAL = DATA_W'((CAS_LAT << 4) | 2);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} st_e;

  st_e               st_q;
  logic [STEP_W-1:0] step_q;
  logic              cke_q, dll_q, ocd_q, done_q;
  logic [REF_W-1:0]  ref_q;

  cmd_e              cur_cmd;
  logic [1:0]        cur_emr;
  act_e              cur_act;
  logic [CNT_W-1:0]  wait_cyc;
  logic              is_cmd, proceed, wait_nz, cnt_last;

  ddr2_init_steps #(
    .CLK_MHZ(CLK_MHZ), .T_PWR_NS(T_PWR_NS), .T_CKE_NS(T_CKE_NS), .T_CMD_NS(T_CMD_NS),
    .T_SETL_NS(T_SETL_NS), .T_RFC_NS(T_RFC_NS), .CNT_W(CNT_W)
  ) u_steps (
    .step_i(step_q), .cmd_o(cur_cmd), .emr_idx_o(cur_emr), .act_o(cur_act), .wait_cyc_o(wait_cyc)
  );

  assign is_cmd  = (cur_cmd != CMD_NONE);
  assign proceed = (st_q == S_ISSUE) && (!is_cmd || cmd_ready_i);
  assign wait_nz = (wait_cyc != '0);

  ddr2_wait_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(proceed && wait_nz), .val_i(wait_cyc), .last_o(cnt_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; step_q <= '0;
      cke_q <= 1'b0; dll_q <= 1'b0; ocd_q <= 1'b0; done_q <= 1'b0; ref_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: st_q <= S_ISSUE;
        S_ISSUE: if (proceed) begin
          unique case (cur_act)
            ACT_CKE_ON:  cke_q <= 1'b1;
            ACT_DLL_SET: dll_q <= 1'b1;
            ACT_DLL_CLR: dll_q <= 1'b0;
            ACT_OCD_SET: ocd_q <= 1'b1;
            ACT_OCD_CLR: ocd_q <= 1'b0;
            ACT_DONE: begin done_q <= 1'b1; ref_q <= REF_INT; end
            default: ;
          endcase
          if (cur_act == ACT_DONE) st_q <= S_DONE;
          else if (wait_nz)        st_q <= S_WAIT;
          else                     step_q <= step_q + 1'b1;
        end
        S_WAIT: if (cnt_last) begin
          st_q   <= S_ISSUE;
          step_q <= step_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign cmd_valid_o   = (st_q == S_ISSUE) && is_cmd;
  assign cmd_type_o    = cmd_valid_o ? cur_cmd : CMD_NOP;
  assign cmd_addr_o    = (cmd_valid_o && cur_cmd == CMD_EMRS) ? (ADDR_W'(cur_emr) << BA_LSB) : '0;
  assign cmd_data_o    = !cmd_valid_o          ? '0 :
                         (cur_cmd == CMD_MRS)  ? MR_VAL :
                         (cur_cmd == CMD_WR)   ? WR_PATTERN : '0;
  assign cke_o         = cke_q;
  assign dll_rst_o     = dll_q;
  assign ocd_dflt_o    = ocd_q;
  assign init_done_o   = done_q;
  assign refresh_int_o = ref_q;

  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_type_o)
                                    && $stable(cmd_addr_o) && $stable(cmd_data_o)); // R2
  AST_EMR_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_type_o == CMD_EMRS |-> cmd_addr_o[BA_LSB +: 2] != 2'd0); // R4
  AST_CKE_BEFORE_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_type_o != CMD_NOP |-> cke_o); // R6
  AST_DLL_OCD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dll_rst_o && ocd_dflt_o)); // R8
  AST_REF_ZERO_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o |-> refresh_int_o == '0); // R10
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> !cmd_valid_o); // R10
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o && $stable(refresh_int_o)); // R10
endmodule

// File: tb/tb_ddr2_init_seq.sv
`timescale 1ns/1ps
module tb_ddr2_init_seq;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        cmd_valid_o, cmd_ready_i;
  logic [2:0]  cmd_type_o;
  logic [31:0] cmd_addr_o, cmd_data_o;
  logic        cke_o, dll_rst_o, ocd_dflt_o, init_done_o;
  logic [11:0] refresh_int_o;

  always #2.5 clk = ~clk;

  ddr2_init_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
    .cmd_type_o(cmd_type_o), .cmd_addr_o(cmd_addr_o), .cmd_data_o(cmd_data_o),
    .cke_o(cke_o), .dll_rst_o(dll_rst_o), .ocd_dflt_o(ocd_dflt_o),
    .init_done_o(init_done_o), .refresh_int_o(refresh_int_o)
  );

  int  n_chk = 0, n_bad = 0;
  longint cyc = 0;
  bit  wd_hit = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !wd_hit) begin
      wd_hit = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung act=%0d exp<=190000", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(string rq, string what, longint unsigned act, longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=0x%0h exp=0x%0h", rq, what, act, exp);
    end
  endtask

  function automatic int cyc_of(int ns);
    return (ns * 200 + 999) / 1000;
  endfunction

  typedef struct {
    int t; int emr; longint unsigned data; int gap; bit cke, dll, ocd;
  } exp_t;

  function automatic exp_t exp_of(int k);
    exp_t e;
    e = '{t: 0, emr: 0, data: 0, gap: 0, cke: (k >= 2), dll: (k >= 6 && k <= 9), ocd: (k == 11)};
    case (k)
      1:  e.gap = cyc_of(200000);
      2:  begin e.t = 1; e.gap = cyc_of(200); end
      3:  begin e.t = 3; e.emr = 2; e.gap = cyc_of(15); end
      4:  begin e.t = 3; e.emr = 3; e.gap = cyc_of(15); end
      5:  begin e.t = 3; e.emr = 1; e.gap = cyc_of(1000); end
      6:  begin e.t = 2; e.data = 64'h32; e.gap = cyc_of(1000) + 1; end
      7:  begin e.t = 1; e.gap = cyc_of(15); end
      8:  begin e.t = 4; e.gap = cyc_of(400); end
      9:  begin e.t = 4; e.gap = cyc_of(400); end
      10: begin e.t = 2; e.data = 64'h32; e.gap = cyc_of(400) + 1; end
      11: begin e.t = 3; e.emr = 1; e.gap = cyc_of(15) + 1 + cyc_of(15); end
      12: begin e.t = 3; e.emr = 1; e.gap = cyc_of(15) + 1 + cyc_of(15); end
      13: begin e.t = 5; e.gap = cyc_of(15); end
      14: begin e.t = 6; e.data = 64'hA5A5A5D1; e.gap = cyc_of(15); end
      default: ;
    endcase
    return e;
  endfunction

  task automatic run_seq(bit stall, int ncmd);
    for (int k = 0; k < ncmd; k++) begin
      exp_t e;
      int gap;
      logic [2:0]  t0;
      logic [31:0] a0;
      bit rdy;
      e = exp_of(k);
      gap = 0;
      while (!cmd_valid_o) begin gap++; @(negedge clk); end
      if (k > 0) chk("R5", $sformatf("gap before cmd %0d", k), gap, e.gap);
      chk("R3", $sformatf("type cmd %0d", k), cmd_type_o, e.t);
      chk("R4", $sformatf("addr cmd %0d", k), cmd_addr_o, longint'(e.emr) << 12);
      chk("R9", $sformatf("data cmd %0d", k), cmd_data_o, e.data);
      chk("R6", $sformatf("cke at cmd %0d", k), cke_o, e.cke);
      chk("R7", $sformatf("dll at cmd %0d", k), dll_rst_o, e.dll);
      chk("R8", $sformatf("ocd at cmd %0d", k), ocd_dflt_o, e.ocd);
      chk("R10", $sformatf("done low at cmd %0d", k), init_done_o, 0);
      t0 = cmd_type_o; a0 = cmd_addr_o;
      forever begin
        rdy = stall ? ($urandom % 3 == 0) : 1'b1;
        cmd_ready_i = rdy;
        @(negedge clk);
        cmd_ready_i = 1'b0;
        if (rdy) break;
        chk("R2", "held while stalled", {cmd_valid_o, cmd_type_o, cmd_addr_o}, {1'b1, t0, a0});
      end
      if (k == 1) chk("R6", "cke rises after 2nd NOP", cke_o, 1);
      if (k == 14) chk("R2", "write taken once", cmd_valid_o, 0);
    end
  endtask

  task automatic check_done();
    chk("R10", "done one cycle after write (before)", {init_done_o, refresh_int_o}, 0);
    @(negedge clk);
    chk("R10", "done set", init_done_o, 1);
    chk("R10", "refresh interval", refresh_int_o, 12'h40F);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cmd_valid_o) chk("R10", "no command after done", cmd_valid_o, 0);
    end
    chk("R10", "done holds", {init_done_o, refresh_int_o}, {1'b1, 12'h40F});
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    rst_ni = 1'b0;
    cmd_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", cmd_valid_o, 0);
    chk("R1", "controls in reset", {cke_o, dll_rst_o, ocd_dflt_o}, 0);
    chk("R1", "done/refresh in reset", {init_done_o, refresh_int_o}, 0);
    rst_ni = 1'b1;

    run_seq(1'b0, 15);
    check_done();

    // restart midway while the DLL-reset bit is high
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    run_seq(1'b1, 8);
    chk("R7", "dll high before mid reset", dll_rst_o, 1);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R11", "controls cleared by reset", {cmd_valid_o, cke_o, dll_rst_o, ocd_dflt_o}, 0);
    chk("R11", "done cleared by reset", init_done_o, 0);
    rst_ni = 1'b1;

    run_seq(1'b1, 15);
    check_done();

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule